// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block is the supervision state machine of a power-management device that powers a microcontroller. After power-on, a rise of the primary rail, or an external pull-down of the reset pin, it waits in a boot state for the microcontroller to write an acknowledge word. If no acknowledge arrives in time, it pulses reset and counts the attempt. After a set number of failed boots it shuts the primary regulator off and parks in a lockout sleep. In lockout, a wake event or its own periodic timer is the only activity.

Once booted, each acknowledge word steers the block. It can arm a timed window that the next acknowledge must beat, pause supervision for a programmed length, drop supervision entirely, or request a regulator-off sleep. All timing is counted in ticks of a 1 ms strobe supplied by the surrounding chip. Serial access, CRC checking and the analog rails lie outside the block.

Top module: `wdg_supervisor`

## Requirements
- R1: Synchronous reset leaves the block in boot with reset released, primary enable on, secondary enable off and the failure count at zero. A pulse on `rail_up_i` in any state returns it to boot. So does `rst_pin_i` sensed low while the block itself is not driving reset low in boot, guarded, free or hold. The status code in `state_o` is 0 boot, 1 failure reset pulse, 2 guarded, 3 free-running, 4 hold, 5 sleep, 6 lockout, 7 wake reset pulse.
- R2: In boot, when STARTUP_MS ticks pass with no acknowledge, the block enters the failure reset pulse and drives `rst_n_o` low.
- R3: The failure reset pulse lasts RST_MS ticks. At its end the failure count rises by one and the block returns to boot.
- R4: When the failure count reaches FAIL_LIMIT, the block enters lockout with `v1_en_o` low, and the count stays at FAIL_LIMIT.
- R5: An acknowledge with no mode bits set enters guarded, with secondary enable on and a window of WIN_BASE_MS shifted left by the 2-bit window field. Each acknowledge inside the window restarts it. If the window runs out, the block returns to boot.
- R6: An acknowledge with the supervision-off bit enters free-running. There it never times out and never drives reset.
- R7: An acknowledge with the hold bit enters hold for (hold field + 1) times HOLD_UNIT_MS ticks. After that it enters guarded, using the window field of the last accepted acknowledge. An acknowledge during hold ends it at once.
- R8: An acknowledge with the regulator-off bit enters sleep, with `v1_en_o` low and reset released. Acknowledges are ignored in sleep. A wake event leaves sleep: with `uv_i` high it goes through a wake reset pulse of RST_MS ticks, and with `uv_i` low it goes straight to boot.
- R9: If `rst_pin_i` is sensed high at any point during a failure reset pulse, that pulse does not raise the failure count.
- R10: In lockout, `timer_wake_o` gives a one-cycle pulse every NAP_PERIOD_MS ticks. A wake event leaves lockout, following the same `uv_i` rule as sleep, and clears the failure count.
- R11: An acknowledge accepted in guarded clears the failure count. An acknowledge accepted in boot leaves it unchanged.
- R12: Among the mode bits of one acknowledge, regulator-off wins over supervision-off, which wins over hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_ms_i | input | 1 | One-cycle strobe per millisecond |
| rail_up_i | input | 1 | Primary rail has just risen |
| rst_pin_i | input | 1 | Sensed level of the reset pin |
| ack_i | input | 1 | Acknowledge write strobe |
| ack_win_sel_i | input | 2 | Window length select |
| ack_win_off_i | input | 1 | Supervision-off bit |
| ack_hold_i | input | 1 | Hold (suspend) bit |
| ack_hold_len_i | input | 4 | Hold length field |
| ack_reg_off_i | input | 1 | Regulator-off (sleep) bit |
| wake_i | input | 1 | Wake event |
| uv_i | input | 1 | Primary rail below its reset threshold |
| rst_n_o | output | 1 | Active-low reset to the microcontroller |
| v1_en_o | output | 1 | Primary regulator enable |
| v2_en_o | output | 1 | Secondary rail enable |
| state_o | output | 3 | Supervisor status code |
| fail_cnt_o | output | FAIL_W | Failed boot count |
| timer_wake_o | output | 1 | Periodic wake pulse in lockout |

## Verification
A wrong state shows up on `state_o` and the rail and reset pins in the clock cycle after the edge that caused it. A wrong tick count stays hidden until a timeout fires early or late, and then it shows as a reset or state change one or more ticks off. A wrong failure count or emulation decision shows on `fail_cnt_o` at the end of the pulse. It also changes how many boots pass before lockout, so the fault is caught one retry sequence later at the latest. A behavioural model checks every output pin on every cycle, so each error is flagged in the cycle it appears.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        ST_BOOT     = 3'd0,
        ST_RSTPULSE = 3'd1,
        ST_GUARD    = 3'd2,
        ST_FREE     = 3'd3,
        ST_HOLD     = 3'd4,
        ST_NAP      = 3'd5,
        ST_LOCKOUT  = 3'd6,
        ST_WAKERST  = 3'd7
    } sup_state_e;

    typedef struct packed {
        logic [1:0] win_sel;
        logic       win_off;
        logic       hold;
        logic [3:0] hold_len;
        logic       reg_off;
    } ack_word_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int win_ticks(input int base, input logic [1:0] sel);
        return base << sel;
    endfunction

    function automatic int hold_ticks(input int unit, input logic [3:0] len);
        return (int'(len) + 1) * unit;
    endfunction

    // states in which the microcontroller may write an acknowledge
    function automatic logic accepts_ack(input sup_state_e s);
        return (s == ST_BOOT) || (s == ST_GUARD) || (s == ST_FREE) || (s == ST_HOLD);
    endfunction

    // states in which the tick timer advances
    function automatic logic timer_live(input sup_state_e s);
        return (s == ST_BOOT) || (s == ST_RSTPULSE) || (s == ST_GUARD) ||
               (s == ST_HOLD) || (s == ST_LOCKOUT) || (s == ST_WAKERST);
    endfunction

endpackage

// File: rtl/wdg_tick_timer.sv
module wdg_tick_timer #(
    parameter int TW      = 9,
    parameter int RST_LIM = 320
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] lim_q;

    assign expire = run && tick && (cnt_q == lim_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= TW'(RST_LIM);
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= load_val;
        end else if (run && tick) begin
            cnt_q <= expire ? '0 : cnt_q + ONE;
        end
    end

    // R2: a running timer never passes its limit
    a_r2_cnt_below_lim: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < lim_q));

endmodule

// File: rtl/wdg_fail_ctr.sv
module wdg_fail_ctr #(
    parameter int LIMIT = 7,
    parameter int FW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [FW-1:0] cnt,
    output logic          last_try
);
    localparam logic [FW-1:0] LIM_V = FW'(LIMIT);

    logic [FW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc && (cnt_q != LIM_V))
            cnt_q <= cnt_q + FW'(1);
    end

    assign cnt      = cnt_q;
    assign last_try = (cnt_q >= LIM_V - FW'(1));

    // R4: the failure count never exceeds its limit
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM_V);

endmodule

// File: rtl/wdg_ack_decode.sv
module wdg_ack_decode
    import wdg_pkg::*;
#(
    parameter int TW          = 9,
    parameter int WIN_BASE_MS = 8,
    parameter int HOLD_UNIT_MS = 16
) (
    input  ack_word_t     ack_w,
    output sup_state_e    dest,
    output logic          load,
    output logic [TW-1:0] load_val
);
    // R12: regulator-off, then supervision-off, then hold, then plain window
    always_comb begin
        dest     = ST_GUARD;
        load     = 1'b1;
        load_val = TW'(win_ticks(WIN_BASE_MS, ack_w.win_sel));
        if (ack_w.reg_off) begin
            dest = ST_NAP;
            load = 1'b0;
        end else if (ack_w.win_off) begin
            dest = ST_FREE;
            load = 1'b0;
        end else if (ack_w.hold) begin
            dest     = ST_HOLD;
            load_val = TW'(hold_ticks(HOLD_UNIT_MS, ack_w.hold_len));
        end
    end

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int STARTUP_MS    = 320,
    parameter int RST_MS        = 1,
    parameter int WIN_BASE_MS   = 8,
    parameter int HOLD_UNIT_MS  = 16,
    parameter int NAP_PERIOD_MS = 100,
    parameter int FAIL_LIMIT    = 7,
    localparam int FAIL_W       = $clog2(FAIL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ms_i,
    input  logic              rail_up_i,
    input  logic              rst_pin_i,
    input  logic              ack_i,
    input  logic [1:0]        ack_win_sel_i,
    input  logic              ack_win_off_i,
    input  logic              ack_hold_i,
    input  logic [3:0]        ack_hold_len_i,
    input  logic              ack_reg_off_i,
    input  logic              wake_i,
    input  logic              uv_i,
    output logic              rst_n_o,
    output logic              v1_en_o,
    output logic              v2_en_o,
    output logic [2:0]        state_o,
    output logic [FAIL_W-1:0] fail_cnt_o,
    output logic              timer_wake_o
);
    localparam int MAX_LIM = max2(max2(STARTUP_MS, RST_MS),
                                  max2(max2(WIN_BASE_MS * 8, HOLD_UNIT_MS * 16), NAP_PERIOD_MS));
    localparam int TW = $clog2(MAX_LIM + 1);
    localparam logic [TW-1:0] START_LIM = TW'(STARTUP_MS);
    localparam logic [TW-1:0] PULSE_LIM = TW'(RST_MS);
    localparam logic [TW-1:0] NAP_LIM   = TW'(NAP_PERIOD_MS);

    sup_state_e    st_q, st_d;
    logic [1:0]    sel_q;
    logic          emu_q;
    logic          tw_q;

    logic          t_exp, ld;
    logic [TW-1:0] ld_val;
    logic          f_clr, f_inc, last_try;
    logic          emu_clr, take_ack, nap_fire;
    logic          supervised, pin_pulled, emu_now;

    ack_word_t     ack_w;
    sup_state_e    dec_dest;
    logic          dec_load;
    logic [TW-1:0] dec_val;
    logic [TW-1:0] win_val;

    assign ack_w = '{win_sel: ack_win_sel_i, win_off: ack_win_off_i, hold: ack_hold_i,
                     hold_len: ack_hold_len_i, reg_off: ack_reg_off_i};

    wdg_ack_decode #(
        .TW(TW), .WIN_BASE_MS(WIN_BASE_MS), .HOLD_UNIT_MS(HOLD_UNIT_MS)
    ) u_dec (
        .ack_w(ack_w), .dest(dec_dest), .load(dec_load), .load_val(dec_val)
    );

    wdg_tick_timer #(.TW(TW), .RST_LIM(STARTUP_MS)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick_ms_i), .run(timer_live(st_q)),
        .load(ld), .load_val(ld_val), .expire(t_exp)
    );

    wdg_fail_ctr #(.LIMIT(FAIL_LIMIT), .FW(FAIL_W)) u_fail (
        .clk(clk), .rst(rst), .clr(f_clr), .inc(f_inc),
        .cnt(fail_cnt_o), .last_try(last_try)
    );

    assign supervised = accepts_ack(st_q);
    assign pin_pulled = supervised && !rst_pin_i;
    assign emu_now    = emu_q || rst_pin_i;
    assign win_val    = TW'(win_ticks(WIN_BASE_MS, sel_q));

    always_comb begin
        st_d     = st_q;
        ld       = 1'b0;
        ld_val   = START_LIM;
        f_clr    = 1'b0;
        f_inc    = 1'b0;
        emu_clr  = 1'b0;
        take_ack = 1'b0;
        nap_fire = 1'b0;
        if (rail_up_i || pin_pulled) begin
            st_d = ST_BOOT;
            ld   = 1'b1;
        end else if (supervised && ack_i) begin
            take_ack = 1'b1;
            st_d     = dec_dest;
            ld       = dec_load;
            ld_val   = dec_val;
            f_clr    = (st_q == ST_GUARD);
        end else begin
            unique case (st_q)
                ST_BOOT: if (t_exp) begin
                    st_d    = ST_RSTPULSE;
                    ld      = 1'b1;
                    ld_val  = PULSE_LIM;
                    emu_clr = 1'b1;
                end
                ST_RSTPULSE: if (t_exp) begin
                    f_inc = !emu_now;
                    ld    = 1'b1;
                    if (!emu_now && last_try) begin
                        st_d   = ST_LOCKOUT;
                        ld_val = NAP_LIM;
                    end else begin
                        st_d = ST_BOOT;
                    end
                end
                ST_GUARD: if (t_exp) begin
                    st_d = ST_BOOT;
                    ld   = 1'b1;
                end
                ST_FREE: ;
                ST_HOLD: if (t_exp) begin
                    st_d   = ST_GUARD;
                    ld     = 1'b1;
                    ld_val = win_val;
                end
                ST_NAP: if (wake_i) begin
                    st_d   = uv_i ? ST_WAKERST : ST_BOOT;
                    ld     = 1'b1;
                    ld_val = uv_i ? PULSE_LIM : START_LIM;
                end
                ST_LOCKOUT: if (wake_i) begin
                    f_clr  = 1'b1;
                    st_d   = uv_i ? ST_WAKERST : ST_BOOT;
                    ld     = 1'b1;
                    ld_val = uv_i ? PULSE_LIM : START_LIM;
                end else if (t_exp) begin
                    ld       = 1'b1;
                    ld_val   = NAP_LIM;
                    nap_fire = 1'b1;
                end
                ST_WAKERST: if (t_exp) begin
                    st_d = ST_BOOT;
                    ld   = 1'b1;
                end
                default: st_d = ST_BOOT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_BOOT;
            sel_q <= '0;
            emu_q <= 1'b0;
            tw_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            tw_q <= nap_fire;
            if (take_ack)
                sel_q <= ack_win_sel_i;
            if (emu_clr)
                emu_q <= 1'b0;
            else if ((st_q == ST_RSTPULSE) && rst_pin_i)
                emu_q <= 1'b1;
        end
    end

    assign rst_n_o      = !((st_q == ST_RSTPULSE) || (st_q == ST_WAKERST));
    assign v1_en_o      = !((st_q == ST_NAP) || (st_q == ST_LOCKOUT));
    assign v2_en_o      = (st_q == ST_GUARD) || (st_q == ST_FREE) || (st_q == ST_HOLD);
    assign state_o      = st_q;
    assign timer_wake_o = tw_q;

    // R2: a failure pulse is only ever entered from boot
    a_r2_pulse_from_boot: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_RSTPULSE) && ($past(st_q) != ST_RSTPULSE)) |-> ($past(st_q) == ST_BOOT));

    // R9: a pulse seen high on the pin never raises the count
    a_r9_emu_no_inc: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) == ST_RSTPULSE) && $past(rst_pin_i)) |-> (fail_cnt_o <= $past(fail_cnt_o)));

    // R6: free-running holds without acknowledge, rail event or pin pull
    a_r6_free_holds: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_FREE) && !ack_i && !rail_up_i && rst_pin_i) |=> (st_q == ST_FREE));

    // R8: sleep is left only by wake or rail event
    a_r8_nap_sticky: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_NAP) && !wake_i && !rail_up_i) |=> (st_q == ST_NAP));

    // R10: wake pulses come only out of lockout
    a_r10_pulse_source: assert property (@(posedge clk) disable iff (rst)
        timer_wake_o |-> ($past(st_q) == ST_LOCKOUT));

endmodule

// File: tb/wdg_supervisor_tb.sv
module wdg_supervisor_tb;
    localparam int P_START = 20;
    localparam int P_PULSE = 2;
    localparam int P_WIN   = 4;
    localparam int P_HOLD  = 3;
    localparam int P_NAP   = 10;
    localparam int P_LIM   = 7;
    localparam int TDIV    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic rail_up = 1'b0, ack = 1'b0, win_off = 1'b0, hold = 1'b0, reg_off = 1'b0;
    logic wake = 1'b0, uv = 1'b0;
    logic [1:0] sel = '0;
    logic [3:0] hlen = '0;
    logic ext_low = 1'b0, emu_force = 1'b0;
    logic rst_pin;
    logic rst_n, v1, v2, tw;
    logic [2:0] st;
    logic [2:0] fc;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1";

    assign rst_pin = (rst_n & ~ext_low) | emu_force;

    always #4 clk = ~clk;

    wdg_supervisor #(
        .STARTUP_MS(P_START), .RST_MS(P_PULSE), .WIN_BASE_MS(P_WIN),
        .HOLD_UNIT_MS(P_HOLD), .NAP_PERIOD_MS(P_NAP), .FAIL_LIMIT(P_LIM)
    ) u_dut (
        .clk(clk), .rst(rst), .tick_ms_i(tick), .rail_up_i(rail_up), .rst_pin_i(rst_pin),
        .ack_i(ack), .ack_win_sel_i(sel), .ack_win_off_i(win_off), .ack_hold_i(hold),
        .ack_hold_len_i(hlen), .ack_reg_off_i(reg_off), .wake_i(wake), .uv_i(uv),
        .rst_n_o(rst_n), .v1_en_o(v1), .v2_en_o(v2), .state_o(st),
        .fail_cnt_o(fc), .timer_wake_o(tw)
    );

    int div = 0;
    always @(negedge clk) begin
        div = (div + 1) % TDIV;
        tick <= (div == 0);
    end

    // behavioural reference model
    int m_st = 0, m_cnt = 0, m_lim = P_START, m_fail = 0, m_sel = 0;
    bit m_emu = 0, m_tw = 0, seen = 0;

    always @(posedge clk) begin
        bit run, ex, ld, sup, fire, en;
        int nst, lv, nf;
        seen = 1;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_lim = P_START; m_fail = 0; m_sel = 0; m_emu = 0; m_tw = 0;
        end else begin
            run  = (m_st == 0) || (m_st == 1) || (m_st == 2) || (m_st == 4) || (m_st == 6) || (m_st == 7);
            ex   = run && tick && (m_cnt == m_lim - 1);
            sup  = (m_st == 0) || (m_st == 2) || (m_st == 3) || (m_st == 4);
            nst  = m_st; ld = 0; lv = P_START; fire = 0;
            if (rail_up || (sup && !rst_pin)) begin
                nst = 0; ld = 1;
            end else if (sup && ack) begin
                if (m_st == 2) m_fail = 0;
                m_sel = sel;
                if (reg_off) nst = 5;
                else if (win_off) nst = 3;
                else if (hold) begin nst = 4; ld = 1; lv = (hlen + 1) * P_HOLD; end
                else begin nst = 2; ld = 1; lv = P_WIN << sel; end
            end else begin
                case (m_st)
                    0: if (ex) begin nst = 1; ld = 1; lv = P_PULSE; m_emu = 0; end
                    1: begin
                        en = m_emu || rst_pin;
                        if (ex) begin
                            nf = m_fail + (en ? 0 : 1);
                            m_fail = nf;
                            ld = 1;
                            if (nf >= P_LIM) begin nst = 6; lv = P_NAP; end
                            else nst = 0;
                        end else if (rst_pin) m_emu = 1;
                    end
                    2: if (ex) begin nst = 0; ld = 1; end
                    4: if (ex) begin nst = 2; ld = 1; lv = P_WIN << m_sel; end
                    5: if (wake) begin nst = uv ? 7 : 0; ld = 1; lv = uv ? P_PULSE : P_START; end
                    6: if (wake) begin
                        m_fail = 0; nst = uv ? 7 : 0; ld = 1; lv = uv ? P_PULSE : P_START;
                    end else if (ex) begin ld = 1; lv = P_NAP; fire = 1; end
                    7: if (ex) begin nst = 0; ld = 1; end
                    default: ;
                endcase
            end
            if (ld) begin m_cnt = 0; m_lim = lv; end
            else if (run && tick) m_cnt = ex ? 0 : m_cnt + 1;
            m_st = nst;
            m_tw = fire;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison of all outputs against the model
    always @(negedge clk) begin
        logic [9:0] a, e;
        if (seen) begin
            a = {st, rst_n, v1, v2, fc, tw};
            e = {m_st[2:0], !(m_st == 1 || m_st == 7), !(m_st == 5 || m_st == 6),
                 (m_st == 2 || m_st == 3 || m_st == 4), m_fail[2:0], m_tw};
            chk(phase, int'(a), int'(e));
        end
    end

    int cyc_n = 0;
    always @(negedge clk) begin
        cyc_n++;
        if (cyc_n > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ack(input logic [1:0] s, input logic wo, input logic h,
                            input logic [3:0] hl, input logic ro);
        @(negedge clk);
        ack = 1'b1; sel = s; win_off = wo; hold = h; hlen = hl; reg_off = ro;
        @(negedge clk);
        ack = 1'b0; sel = '0; win_off = 1'b0; hold = 1'b0; hlen = '0; reg_off = 1'b0;
    endtask

    task automatic pulse_wake(input logic u);
        @(negedge clk);
        wake = 1'b1; uv = u;
        @(negedge clk);
        wake = 1'b0; uv = 1'b0;
    endtask

    task automatic wait_st(input int s, input int lim, input string req);
        int k = 0;
        while (int'(st) != s && k < lim) begin
            @(negedge clk);
            k++;
        end
        chk(req, int'(st), s);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1", int'(st), 0); chk("R1", int'(rst_n), 1); chk("R1", int'(v1), 1);
        chk("R1", int'(v2), 0); chk("R1", int'(fc), 0);

        // R2 / R3 / R4 boot retries into lockout
        phase = "R2";
        wait_st(1, 120, "R2");
        chk("R2", int'(rst_n), 0);
        phase = "R3";
        wait_st(0, 20, "R3");
        chk("R3", int'(fc), 1);
        phase = "R4";
        wait_st(6, 2000, "R4");
        chk("R4", int'(fc), P_LIM);
        chk("R4", int'(v1), 0);

        // R10 periodic wake pulses and wake-out
        phase = "R10";
        begin
            int pulses = 0;
            repeat (400) begin
                @(negedge clk);
                if (tw) pulses++;
            end
            chk("R10", pulses, 10);
        end
        pulse_wake(1'b1);
        chk("R10", int'(st), 7);
        chk("R10", int'(fc), 0);
        chk("R8", int'(rst_n), 0);
        wait_st(0, 20, "R8");

        // R5 guarded window
        phase = "R5";
        send_ack(2'd1, 0, 0, 4'd0, 0);
        chk("R5", int'(st), 2); chk("R5", int'(v2), 1);
        repeat (3) begin
            cyc(20);
            send_ack(2'd1, 0, 0, 4'd0, 0);
        end
        chk("R5", int'(st), 2);
        cyc(28);
        chk("R5", int'(st), 2);
        cyc(12);
        chk("R5", int'(st), 0);

        // R11 failure count clearing
        phase = "R11";
        wait_st(1, 120, "R11");
        wait_st(0, 20, "R11");
        chk("R11", int'(fc), 1);
        send_ack(2'd0, 0, 0, 4'd0, 0);
        chk("R11", int'(st), 2);
        chk("R11", int'(fc), 1);
        send_ack(2'd0, 0, 0, 4'd0, 0);
        chk("R11", int'(fc), 0);

        // R7 hold then window from stored select
        phase = "R7";
        send_ack(2'd3, 0, 1, 4'd2, 0);
        chk("R7", int'(st), 4);
        cyc(28);
        chk("R7", int'(st), 4);
        cyc(20);
        chk("R7", int'(st), 2);
        send_ack(2'd0, 0, 1, 4'd2, 0);
        cyc(8);
        send_ack(2'd2, 0, 0, 4'd0, 0);
        chk("R7", int'(st), 2);

        // R6 free-running
        phase = "R6";
        send_ack(2'd0, 1, 0, 4'd0, 0);
        cyc(400);
        chk("R6", int'(st), 3);
        chk("R6", int'(rst_n), 1);

        // R12 / R8 sleep entry, ignored acknowledge, plain wake
        phase = "R12";
        send_ack(2'd0, 1, 1, 4'd0, 1);
        chk("R12", int'(st), 5);
        chk("R8", int'(v1), 0);
        chk("R8", int'(rst_n), 1);
        phase = "R8";
        send_ack(2'd0, 0, 0, 4'd0, 0);
        chk("R8", int'(st), 5);
        pulse_wake(1'b0);
        chk("R8", int'(st), 0);
        chk("R8", int'(rst_n), 1);

        // R9 emulation keeps the count
        phase = "R9";
        wait_st(1, 120, "R9");
        emu_force = 1'b1;
        wait_st(0, 20, "R9");
        emu_force = 1'b0;
        chk("R9", int'(fc), 0);

        // R1 external pin pull and rail event
        phase = "R1";
        send_ack(2'd3, 0, 0, 4'd0, 0);
        chk("R1", int'(st), 2);
        @(negedge clk); ext_low = 1'b1;
        @(negedge clk); ext_low = 1'b0;
        chk("R1", int'(st), 0);
        phase = "R12";
        send_ack(2'd0, 1, 1, 4'd5, 0);
        chk("R12", int'(st), 3);
        phase = "R1";
        @(negedge clk); rail_up = 1'b1;
        @(negedge clk); rail_up = 1'b0;
        chk("R1", int'(st), 0);
        cyc(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule